// File: doc/BRIEF.md
# Stack Bytecode Execution Core

This block runs a small set of stack-machine bytecodes. It reads opcode and operand bytes one at a time from a byte-wide program memory outside the block. It keeps the operand stack and the local-variable frame in an internal 32-bit data memory. The top of the stack is also held in a register, and a stack pointer and a fixed frame base locate the words in memory. Each instruction passes through a multi-cycle state machine. The machine fetches the bytes the opcode needs, issues memory reads, waits one cycle for each read, and then writes results back.

The program memory has a synchronous read port with one cycle of latency. The core drives the byte address, and the byte appears on the following cycle. Output bytes appear on a character port with a single-cycle strobe. The core reports a normal stop, or an unknown opcode together with that opcode's address.

Top module: `sbc_core`

## Requirements
- R1: While reset is high and on the first cycle after it, the stack pointer reads 1023 (frame base 1024 minus one), the top-of-stack reads 0, all flags and the output strobe are low, and the first program address driven is 0.
- R2: Opcode 0x10 fetches one operand byte, sign-extends it to 32 bits, raises the stack pointer by one, writes the value at the new stack pointer and makes it the top of stack.
- R3: Opcodes 0x60 (add), 0x64 (subtract), 0x7E (and) and 0xB0 (or) lower the stack pointer by one. Each combines the word found there with the old top of stack and stores the 32-bit wrapped result there and in the top of stack. Subtract yields the lower word minus the old top.
- R4: Opcode 0x59 pushes a copy of the top of stack. Opcode 0x57 lowers the stack pointer and reloads the top of stack from memory. Opcode 0x5F exchanges the two uppermost stack words. No instruction moves the stack pointer by more than one per cycle.
- R5: Opcode 0x15 pushes the word at frame base plus an unsigned 8-bit index. Opcode 0x36 stores the top of stack there, then lowers the stack pointer and reloads the top of stack.
- R6: Opcode 0x84 takes an unsigned index byte and then a signed 8-bit constant, and adds the constant to the frame word at that index.
- R7: Opcode 0xA7 takes a 16-bit signed offset, high byte first, and jumps to the address of the opcode itself plus the offset. Backward offsets work.
- R8: Opcodes 0x99 (branch if zero) and 0x9B (branch if negative) pop the top of stack and branch as in R7 when the popped value meets the test. Otherwise they skip both offset bytes.
- R9: Opcode 0xFD fetches one byte and shows it on the character port for exactly one cycle with the strobe high.
- R10: Opcode 0xFF raises the halted flag. The flag stays high, the program address stays frozen and no more characters appear until reset.
- R11: Any other opcode raises the error flag. It records that opcode's address, holds both, and executes nothing further. Halted and error are never high together.
- R12: Opcode 0x00 changes no stack state and moves on to the next byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pmem_addr | output | PADDR_W | Byte address to program memory |
| pmem_rdata | input | 8 | Program byte, valid one cycle after the address |
| out_valid | output | 1 | One-cycle strobe for out_char |
| out_char | output | 8 | Output character byte |
| halted | output | 1 | Stop instruction reached |
| error | output | 1 | Unknown opcode met |
| fault_pc | output | PADDR_W | Address of the unknown opcode |
| tos_o | output | 32 | Current top-of-stack register |
| sp_o | output | DADDR_W | Current stack pointer |

## Verification
The assertions rely on program memory returning exactly the byte at the address driven one cycle earlier, with no stalls. They also rely on reset being held from time zero. The bench ROM is a single registered array that is reloaded only while reset is high, so both conditions hold. Every test program first pushes a defined base word. As a result, pops never reload the top of stack from uninitialised memory. All branch targets land on valid opcodes, and unused ROM bytes hold an illegal opcode, so a stray jump shows up as an error.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  localparam int WORD_W = 32;

  localparam logic [7:0] OP_NOP    = 8'h00;
  localparam logic [7:0] OP_BIPUSH = 8'h10;
  localparam logic [7:0] OP_ILOAD  = 8'h15;
  localparam logic [7:0] OP_ISTORE = 8'h36;
  localparam logic [7:0] OP_POP    = 8'h57;
  localparam logic [7:0] OP_DUP    = 8'h59;
  localparam logic [7:0] OP_SWAP   = 8'h5F;
  localparam logic [7:0] OP_IADD   = 8'h60;
  localparam logic [7:0] OP_ISUB   = 8'h64;
  localparam logic [7:0] OP_IAND   = 8'h7E;
  localparam logic [7:0] OP_IINC   = 8'h84;
  localparam logic [7:0] OP_IFEQ   = 8'h99;
  localparam logic [7:0] OP_IFLT   = 8'h9B;
  localparam logic [7:0] OP_GOTO   = 8'hA7;
  localparam logic [7:0] OP_IOR    = 8'hB0;
  localparam logic [7:0] OP_OUT    = 8'hFD;
  localparam logic [7:0] OP_HALT   = 8'hFF;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR} alu_op_e;

  typedef enum logic [4:0] {
    S_FETCH, S_FBYTE, S_DECODE, S_RWAIT, S_WR,
    X_PUSHB, X_ALU, X_RELOAD, X_SW1, X_SW2, X_LOCAL, X_LDPUSH, X_STPOP,
    X_INC1, X_INC2, X_BRHI, X_BRLO, X_COND, X_CHAR, S_HALT, S_ERR
  } state_e;
endpackage

// File: rtl/sbc_alu.sv
module sbc_alu import sbc_pkg::*; #(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      default: y = a | b;
    endcase
  end
endmodule

// File: rtl/sbc_dmem.sv
module sbc_dmem #(
  parameter int AW = 11,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] ram [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) ram[addr] <= wdata;
    rdata <= ram[addr];
  end
endmodule

// File: rtl/sbc_core.sv
module sbc_core import sbc_pkg::*; #(
  parameter int PADDR_W = 16,
  parameter int DADDR_W = 11,
  parameter int LV_BASE = 1024
) (
  input  logic               clk,
  input  logic               rst,
  output logic [PADDR_W-1:0] pmem_addr,
  input  logic [7:0]         pmem_rdata,
  output logic               out_valid,
  output logic [7:0]         out_char,
  output logic               halted,
  output logic               error,
  output logic [PADDR_W-1:0] fault_pc,
  output logic [WORD_W-1:0]  tos_o,
  output logic [DADDR_W-1:0] sp_o
);
  localparam logic [DADDR_W-1:0] LV     = DADDR_W'(LV_BASE);
  localparam logic [DADDR_W-1:0] SP_RST = DADDR_W'(LV_BASE - 1);

  state_e state_q, fret_q, cont_q;
  logic [PADDR_W-1:0] pc_q, oppc_q;
  logic [7:0]         ir_q, mbr_q;
  logic [DADDR_W-1:0] sp_q, mar_q;
  logic [WORD_W-1:0]  tos_q, h_q, opc_q, wdat_q;
  logic [WORD_W-1:0]  mem_rdata, alu_y, mbr_s, mbr_u, br_off;
  logic [DADDR_W-1:0] sp_p1, sp_m1;
  logic               mem_we, take;
  alu_op_e            alu_op;

  assign mbr_s  = {{(WORD_W-8){mbr_q[7]}}, mbr_q};
  assign mbr_u  = {{(WORD_W-8){1'b0}}, mbr_q};
  assign br_off = h_q | mbr_u;
  assign sp_p1  = sp_q + DADDR_W'(1);
  assign sp_m1  = sp_q - DADDR_W'(1);
  assign mem_we = (state_q == S_WR);
  assign take   = (ir_q == OP_IFEQ) ? (opc_q == '0) : opc_q[WORD_W-1];

  always_comb begin
    unique case (ir_q)
      OP_ISUB: alu_op = ALU_SUB;
      OP_IAND: alu_op = ALU_AND;
      OP_IOR:  alu_op = ALU_OR;
      default: alu_op = ALU_ADD;
    endcase
  end

  sbc_alu #(.W(WORD_W)) u_alu (.op(alu_op), .a(mem_rdata), .b(h_q), .y(alu_y));

  sbc_dmem #(.AW(DADDR_W), .DW(WORD_W)) u_dmem (
    .clk(clk), .we(mem_we), .addr(mar_q), .wdata(wdat_q), .rdata(mem_rdata));

  assign pmem_addr = pc_q;
  assign tos_o     = tos_q;
  assign sp_o      = sp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_FETCH; fret_q <= S_DECODE; cont_q <= S_FETCH;
      pc_q <= '0; oppc_q <= '0; ir_q <= OP_NOP; mbr_q <= '0;
      sp_q <= SP_RST; mar_q <= SP_RST;
      tos_q <= '0; h_q <= '0; opc_q <= '0; wdat_q <= '0;
      out_valid <= 1'b0; out_char <= '0;
      halted <= 1'b0; error <= 1'b0; fault_pc <= '0;
    end else begin
      out_valid <= 1'b0;
      unique case (state_q)
        S_FETCH: state_q <= S_FBYTE;
        S_FBYTE: begin
          mbr_q <= pmem_rdata;
          pc_q  <= pc_q + PADDR_W'(1);
          if (fret_q == S_DECODE) begin
            ir_q   <= pmem_rdata;
            oppc_q <= pc_q;
          end
          state_q <= fret_q;
        end
        S_RWAIT: state_q <= cont_q;
        S_WR:    state_q <= cont_q;
        S_DECODE: begin
          unique case (ir_q)
            OP_NOP: begin state_q <= S_FETCH; fret_q <= S_DECODE; end
            OP_BIPUSH: begin state_q <= S_FETCH; fret_q <= X_PUSHB; end
            OP_OUT:    begin state_q <= S_FETCH; fret_q <= X_CHAR; end
            OP_GOTO:   begin state_q <= S_FETCH; fret_q <= X_BRHI; end
            OP_ILOAD, OP_ISTORE, OP_IINC: begin state_q <= S_FETCH; fret_q <= X_LOCAL; end
            OP_IADD, OP_ISUB, OP_IAND, OP_IOR: begin
              sp_q <= sp_m1; mar_q <= sp_m1; h_q <= tos_q;
              cont_q <= X_ALU; state_q <= S_RWAIT;
            end
            OP_POP: begin
              sp_q <= sp_m1; mar_q <= sp_m1; cont_q <= X_RELOAD; state_q <= S_RWAIT;
            end
            OP_DUP: begin
              sp_q <= sp_p1; mar_q <= sp_p1; wdat_q <= tos_q;
              cont_q <= S_FETCH; fret_q <= S_DECODE; state_q <= S_WR;
            end
            OP_SWAP: begin
              mar_q <= sp_m1; cont_q <= X_SW1; state_q <= S_RWAIT;
            end
            OP_IFEQ, OP_IFLT: begin
              sp_q <= sp_m1; mar_q <= sp_m1; opc_q <= tos_q;
              cont_q <= X_COND; state_q <= S_RWAIT;
            end
            OP_HALT: begin halted <= 1'b1; state_q <= S_HALT; end
            default: begin error <= 1'b1; fault_pc <= oppc_q; state_q <= S_ERR; end
          endcase
        end
        X_PUSHB: begin
          sp_q <= sp_p1; mar_q <= sp_p1; wdat_q <= mbr_s; tos_q <= mbr_s;
          cont_q <= S_FETCH; fret_q <= S_DECODE; state_q <= S_WR;
        end
        X_ALU: begin
          tos_q <= alu_y; wdat_q <= alu_y;
          cont_q <= S_FETCH; fret_q <= S_DECODE; state_q <= S_WR;
        end
        X_RELOAD: begin
          tos_q <= mem_rdata; fret_q <= S_DECODE; state_q <= S_FETCH;
        end
        X_SW1: begin
          h_q <= mem_rdata; wdat_q <= mem_rdata; mar_q <= sp_q;
          cont_q <= X_SW2; state_q <= S_WR;
        end
        X_SW2: begin
          mar_q <= sp_m1; wdat_q <= tos_q; tos_q <= h_q;
          cont_q <= S_FETCH; fret_q <= S_DECODE; state_q <= S_WR;
        end
        X_LOCAL: begin
          mar_q <= LV + DADDR_W'(mbr_q);
          if (ir_q == OP_ILOAD) begin
            cont_q <= X_LDPUSH; state_q <= S_RWAIT;
          end else if (ir_q == OP_ISTORE) begin
            wdat_q <= tos_q; cont_q <= X_STPOP; state_q <= S_WR;
          end else begin
            cont_q <= X_INC1; state_q <= S_RWAIT;
          end
        end
        X_LDPUSH: begin
          sp_q <= sp_p1; mar_q <= sp_p1; wdat_q <= mem_rdata; tos_q <= mem_rdata;
          cont_q <= S_FETCH; fret_q <= S_DECODE; state_q <= S_WR;
        end
        X_STPOP: begin
          sp_q <= sp_m1; mar_q <= sp_m1; cont_q <= X_RELOAD; state_q <= S_RWAIT;
        end
        X_INC1: begin
          h_q <= mem_rdata; fret_q <= X_INC2; state_q <= S_FETCH;
        end
        X_INC2: begin
          wdat_q <= h_q + mbr_s;
          cont_q <= S_FETCH; fret_q <= S_DECODE; state_q <= S_WR;
        end
        X_BRHI: begin
          h_q <= {mbr_s[WORD_W-9:0], 8'h00}; fret_q <= X_BRLO; state_q <= S_FETCH;
        end
        X_BRLO: begin
          pc_q <= oppc_q + br_off[PADDR_W-1:0];
          fret_q <= S_DECODE; state_q <= S_FETCH;
        end
        X_COND: begin
          tos_q <= mem_rdata;
          state_q <= S_FETCH;
          if (take) fret_q <= X_BRHI;
          else begin
            pc_q <= pc_q + PADDR_W'(2); fret_q <= S_DECODE;
          end
        end
        X_CHAR: begin
          out_valid <= 1'b1; out_char <= mbr_q;
          fret_q <= S_DECODE; state_q <= S_FETCH;
        end
        S_HALT: state_q <= S_HALT;
        default: state_q <= S_ERR;
      endcase
    end
  end

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && $stable(pmem_addr) && !out_valid); // R10
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    error |=> error && $stable(fault_pc) && !out_valid); // R11
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(halted && error)); // R11
  AST_CHAR_PULSE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R9
  AST_SP_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
    (sp_q != $past(sp_q)) |-> (sp_q == $past(sp_q) + DADDR_W'(1) ||
                               sp_q == $past(sp_q) - DADDR_W'(1))); // R4
endmodule

// File: tb/sbc_core_bench.sv
module sbc_core_bench;
  localparam int PW = 16;
  localparam int DW = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [PW-1:0] pmem_addr, fault_pc;
  logic [7:0] pmem_rdata, out_char;
  logic out_valid, halted, error;
  logic [31:0] tos_o;
  logic [DW-1:0] sp_o;

  always #5 clk = ~clk;

  sbc_core #(.PADDR_W(PW), .DADDR_W(DW), .LV_BASE(1024)) u_sbc_core (
    .clk(clk), .rst(rst), .pmem_addr(pmem_addr), .pmem_rdata(pmem_rdata),
    .out_valid(out_valid), .out_char(out_char), .halted(halted), .error(error),
    .fault_pc(fault_pc), .tos_o(tos_o), .sp_o(sp_o));

  logic [7:0] rom [0:4095];
  always_ff @(posedge clk) pmem_rdata <= rom[pmem_addr[11:0]];

  typedef struct packed {
    logic [1:0]  kind;  // 0 char, 1 halt, 2 error
    logic [31:0] val;
    logic [15:0] aux;
  } exp_t;
  exp_t  sbq[$];
  string tagq[$];
  logic [7:0] prog[$];
  int checks = 0;
  int errors = 0;
  logic prev_h = 1'b0, prev_e = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic expect_char(input logic [7:0] c, input string tag);
    sbq.push_back('{kind: 2'd0, val: {24'h0, c}, aux: 16'h0}); tagq.push_back(tag);
  endtask
  task automatic expect_halt(input logic [31:0] t, input logic [15:0] s, input string tag);
    sbq.push_back('{kind: 2'd1, val: t, aux: s}); tagq.push_back(tag);
  endtask
  task automatic expect_err(input logic [15:0] f, input string tag);
    sbq.push_back('{kind: 2'd2, val: 32'h0, aux: f}); tagq.push_back(tag);
  endtask

  // monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (rst) begin
      prev_h <= 1'b0; prev_e <= 1'b0;
    end else begin
      if (out_valid) begin
        if (sbq.size() == 0) check(1'b0, "R9", "unexpected char", {24'h0, out_char}, 32'h0);
        else begin
          exp_t e; string t;
          e = sbq.pop_front(); t = tagq.pop_front();
          check(e.kind == 2'd0, t, "kind at char", {30'h0, e.kind}, 32'h0);
          check(out_char == e.val[7:0], t, "char", {24'h0, out_char}, e.val);
        end
      end
      if (halted && !prev_h) begin
        if (sbq.size() == 0) check(1'b0, "R10", "unexpected halt", 32'h1, 32'h0);
        else begin
          exp_t e; string t;
          e = sbq.pop_front(); t = tagq.pop_front();
          check(e.kind == 2'd1, t, "kind at halt", {30'h0, e.kind}, 32'h1);
          check(tos_o == e.val, t, "tos at halt", tos_o, e.val);
          check(sp_o == e.aux[DW-1:0], t, "sp at halt", {21'h0, sp_o}, {16'h0, e.aux});
        end
      end
      if (error && !prev_e) begin
        if (sbq.size() == 0) check(1'b0, "R11", "unexpected error", 32'h1, 32'h0);
        else begin
          exp_t e; string t;
          e = sbq.pop_front(); t = tagq.pop_front();
          check(e.kind == 2'd2, t, "kind at error", {30'h0, e.kind}, 32'h2);
          check(fault_pc == e.aux, t, "fault address", {16'h0, fault_pc}, {16'h0, e.aux});
        end
      end
      prev_h <= halted; prev_e <= error;
    end
  end

  task automatic run_prog(input string tag);
    int n;
    rst = 1'b1;
    for (int i = 0; i < 4096; i++) rom[i] = 8'h12;  // illegal filler
    for (int i = 0; i < prog.size(); i++) rom[i] = prog[i];
    repeat (3) @(negedge clk);
    check(sp_o == 11'd1023, "R1", "reset sp", {21'h0, sp_o}, 32'd1023);
    check(tos_o == 32'h0 && !halted && !error && !out_valid, "R1", "reset tos/flags",
          tos_o, 32'h0);
    check(pmem_addr == 16'h0, "R1", "reset fetch address", {16'h0, pmem_addr}, 32'h0);
    rst = 1'b0;
    n = 0;
    while (!halted && !error && n < 3000) begin @(negedge clk); n++; end
    if (n >= 3000) check(1'b0, tag, "program timeout", n, 3000);
    repeat (20) @(negedge clk);
    check(sbq.size() == 0, tag, "items left in scoreboard", sbq.size(), 0);
  endtask

  initial begin
    // R2 R3 R12 R9 R10: push, add, nop, subtract, char, halt
    prog = {8'h10, 8'h05, 8'h10, 8'hFD, 8'h60, 8'h00, 8'h10, 8'h07, 8'h64,
            8'hFD, 8'h41, 8'hFF};
    expect_char(8'h41, "R9");
    expect_halt(32'hFFFF_FFFB, 16'd1024, "R3");
    run_prog("R2");
    begin
      logic [PW-1:0] a0;
      a0 = pmem_addr;
      repeat (10) @(negedge clk);
      check(halted && pmem_addr == a0, "R10", "halt held, address frozen",
            {16'h0, pmem_addr}, {16'h0, a0});
    end

    // R3 R4: and, or, dup, swap, pop
    prog = {8'h10, 8'h0C, 8'h10, 8'h0A, 8'h7E, 8'h10, 8'h03, 8'hB0, 8'h59,
            8'h10, 8'h02, 8'h5F, 8'h57, 8'h10, 8'h09, 8'h64, 8'hFF};
    expect_halt(32'hFFFF_FFF9, 16'd1025, "R4");
    run_prog("R4");

    // R5 R6: store, increment, load
    prog = {8'h10, 8'h01, 8'h10, 8'h2A, 8'h36, 8'hC8, 8'h84, 8'hC8, 8'hF6,
            8'h15, 8'hC8, 8'h60, 8'h84, 8'hC8, 8'h90, 8'h15, 8'hC8, 8'h64, 8'hFF};
    expect_halt(32'd113, 16'd1024, "R6");
    run_prog("R5");

    // R7 R8: conditional branches both ways, forward and backward jumps
    prog = {8'h10, 8'h00, 8'h10, 8'h00, 8'h99, 8'h00, 8'h06, 8'hFD, 8'h58, 8'h00,
            8'h10, 8'h05, 8'h99, 8'h00, 8'h10, 8'hFD, 8'h42,
            8'h10, 8'hFF, 8'h9B, 8'h00, 8'h05, 8'hFD, 8'h59, 8'hFD, 8'h43,
            8'h10, 8'h01, 8'h9B, 8'h00, 8'h04, 8'hA7, 8'h00, 8'h05, 8'hFD, 8'h5A,
            8'hFD, 8'h44, 8'hA7, 8'h00, 8'h06, 8'hFD, 8'h45, 8'hFF,
            8'hA7, 8'hFF, 8'hFD};
    expect_char(8'h42, "R8");
    expect_char(8'h43, "R8");
    expect_char(8'h44, "R7");
    expect_char(8'h45, "R7");
    expect_halt(32'h0, 16'd1024, "R8");
    run_prog("R7");

    // R11: unknown opcode at address 3, later char must never appear
    prog = {8'h00, 8'h10, 8'h03, 8'h12, 8'hFD, 8'h46, 8'hFF};
    expect_err(16'd3, "R11");
    run_prog("R11");
    check(error && !halted && fault_pc == 16'd3, "R11", "error held",
          {16'h0, fault_pc}, 32'd3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(10 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule